// File: doc/BRIEF.md
# Masked Write-One-to-Clear Interrupt Unit

This block keeps the interrupt state of one serial bus channel: a 15-bit enable register, a 15-bit status register, a registered interrupt line and this channel's contribution to a status word shared by all channels. Event pulses from the bus engine set status bits. Software clears them by writing ones. Whenever a raise is requested, the status is first pruned to the enabled bits. The line then asserts if anything is left.

The unit also lets a receive sequence run byte by byte. When software acknowledges a receive completion while a receive command is still pending, the unit emits a one-cycle re-arm pulse so that the sequencer fetches the next byte. The cycle of that pulse counts as a raise, so the status and the line are evaluated again.

All outputs are registered. A request presented in cycle t appears on the outputs after the clock edge that ends cycle t.

Top module: `bus_irq_unit`

## Requirements
- R1: After reset, the enable register, the status register, the interrupt line, the shared-word vector and the re-arm pulse are all zero.
- R2: An enable write stores all 15 data bits. The new value is visible on `en_o` after the next clock edge and is used by raises from the following cycle on.
- R3: A 1 on bit k of `evt_i` sets status bit k at the next edge. A status bit never goes from 0 to 1 without an event on that bit. The status bit positions are: 0 transmit acknowledged, 1 transmit not acknowledged, 2 receive done, 3 arbitration lost, 4 normal stop, 5 abnormal stop, 6 clock-line timeout, 13 bus recovery done, 14 data-line timeout.
- R4: An acknowledge write clears exactly the status bits whose data bit is 1, across all 15 positions, and leaves every other bit unchanged.
- R5: If an event arrives in the same cycle as an acknowledge write to the same bit, the event wins and the bit stays set.
- R6: On a raise, the status after the events and clears of that cycle is ANDed with the current enable register. If the result is nonzero, the line asserts at the next edge.
- R7: A raise whose masked result is zero prunes the status to zero but leaves the line at its previous value.
- R8: An acknowledge write whose resulting status is zero deasserts the line. If the resulting status is nonzero, the line keeps its value.
- R9: `gbl_vec_o` carries the line value at bit position BUS_ID and zeros at every other position.
- R10: `rearm_o` pulses for one cycle after an acknowledge write in which data bit 2 is 1, status bit 2 was set and `rx_pend_i` was high. If any one of these three conditions is missing, there is no pulse.
- R11: The cycle in which `rearm_o` is high is treated as a raise, even when `raise_i` is low.
- R12: Status set by events, with no raise, does not assert the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 15 | Enable write data |
| ack_wr_i | input | 1 | Acknowledge (write-one-to-clear) strobe |
| ack_bits_i | input | 15 | Bits to clear |
| evt_i | input | 15 | Event pulses that set status bits |
| raise_i | input | 1 | Raise request: prune status and evaluate the line |
| rx_pend_i | input | 1 | A receive or receive-last command is still pending |
| en_o | output | 15 | Enable register |
| stat_o | output | 15 | Status register |
| irq_o | output | 1 | Registered interrupt line |
| gbl_vec_o | output | NUM_BUS | This channel's bit in the shared status word |
| rearm_o | output | 1 | One-cycle re-arm pulse for the receive sequencer |

## Verification
The bench targets the cycle where an event and an acknowledge hit the same bit. A design that lets the clear win would lose that event and would never raise the line for it. It checks that a raise with nothing enabled leaves a high line high. A design that drops the line there would miss the later acknowledge that is supposed to lower it. The re-arm pulse is checked with each of its three conditions removed in turn, and again in the pulse cycle, where the design must raise with no request. A design that skipped that implicit raise would leave the next byte's completion silent.

// File: rtl/bus_irq_pkg.sv
package bus_irq_pkg;
  localparam int STAT_W      = 15;
  localparam int IDX_TX_ACK  = 0;
  localparam int IDX_TX_NAK  = 1;
  localparam int IDX_RX_DONE = 2;
  localparam int IDX_ARB     = 3;
  localparam int IDX_STOP    = 4;
  localparam int IDX_ABN     = 5;
  localparam int IDX_SCL_TO  = 6;
  localparam int IDX_RECOV   = 13;
  localparam int IDX_SDA_TO  = 14;

  typedef logic [STAT_W-1:0] stat_t;

  // Events override clears for their own bits.
  function automatic stat_t merge_w1c(stat_t cur, logic clr_en, stat_t clr_bits,
                                      stat_t set_bits);
    stat_t clr_mask;
    clr_mask = clr_en ? clr_bits : '0;
    return (cur & ~clr_mask) | set_bits;
  endfunction

  // Pruning by the enable register on a raise.
  function automatic stat_t prune_on_raise(stat_t s, logic raise, stat_t en);
    return raise ? (s & en) : s;
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import bus_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_i,
  input  stat_t wdata_i,
  output stat_t en_o
);
  stat_t en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  AST_EN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_q == $past(wdata_i))); // R2
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import bus_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr_wr_i,
  input  stat_t clr_bits_i,
  input  stat_t set_bits_i,
  input  logic  raise_i,
  input  stat_t en_i,
  output stat_t stat_o,
  output stat_t stat_next_o
);
  stat_t stat_q;
  stat_t merged;
  stat_t stat_d;

  always_comb begin
    merged = merge_w1c(stat_q, clr_wr_i, clr_bits_i, set_bits_i);
    stat_d = prune_on_raise(merged, raise_i, en_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o      = stat_q;
  assign stat_next_o = stat_d;

  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(set_bits_i)) == '0)); // R3
  AST_RAISE_PRUNES: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> ((stat_q & ~$past(en_i)) == '0)); // R6
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise_i && clr_wr_i) |=> ((($past(set_bits_i)) & ~stat_q) == '0)); // R5
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_i,
  input  logic next_nz_i,
  input  logic clr_wr_i,
  input  logic clr_rx_bit_i,
  input  logic rx_stat_i,
  input  logic rx_pend_i,
  output logic irq_o,
  output logic rearm_o
);
  logic irq_q;
  logic rearm_q;
  logic line_set;
  logic line_drop;
  logic rearm_d;

  assign line_set  = raise_i && next_nz_i;
  assign line_drop = clr_wr_i && !next_nz_i;
  assign rearm_d   = clr_wr_i && clr_rx_bit_i && rx_stat_i && rx_pend_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      if (line_set)       irq_q <= 1'b1;
      else if (line_drop) irq_q <= 1'b0;
      rearm_q <= rearm_d;
    end
  end

  assign irq_o   = irq_q;
  assign rearm_o = rearm_q;

  AST_RISE_NEEDS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(raise_i)); // R6
  AST_FALL_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(clr_wr_i)); // R8
  AST_REARM_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_q |-> ($past(rx_stat_i) && $past(rx_pend_i))); // R10
endmodule

// File: rtl/bus_irq_unit.sv
module bus_irq_unit
  import bus_irq_pkg::*;
#(
  parameter int NUM_BUS = 16,
  parameter int BUS_ID  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr_i,
  input  logic [STAT_W-1:0]  en_wdata_i,
  input  logic               ack_wr_i,
  input  logic [STAT_W-1:0]  ack_bits_i,
  input  logic [STAT_W-1:0]  evt_i,
  input  logic               raise_i,
  input  logic               rx_pend_i,
  output logic [STAT_W-1:0]  en_o,
  output logic [STAT_W-1:0]  stat_o,
  output logic               irq_o,
  output logic [NUM_BUS-1:0] gbl_vec_o,
  output logic               rearm_o
);
  stat_t en_w;
  stat_t stat_w;
  stat_t stat_next_w;
  logic  raise_eff;
  logic  irq_w;
  logic  rearm_w;

  // A re-arm cycle re-evaluates the masked status like a raise.
  assign raise_eff = raise_i | rearm_w;

  irq_enable_reg u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (en_wr_i),
    .wdata_i (en_wdata_i),
    .en_o    (en_w)
  );

  irq_status_reg u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_wr_i    (ack_wr_i),
    .clr_bits_i  (ack_bits_i),
    .set_bits_i  (evt_i),
    .raise_i     (raise_eff),
    .en_i        (en_w),
    .stat_o      (stat_w),
    .stat_next_o (stat_next_w)
  );

  irq_line_ctrl u_line (
    .clk          (clk),
    .rst_n        (rst_n),
    .raise_i      (raise_eff),
    .next_nz_i    (|stat_next_w),
    .clr_wr_i     (ack_wr_i),
    .clr_rx_bit_i (ack_bits_i[IDX_RX_DONE]),
    .rx_stat_i    (stat_w[IDX_RX_DONE]),
    .rx_pend_i    (rx_pend_i),
    .irq_o        (irq_w),
    .rearm_o      (rearm_w)
  );

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_gbl
    if (b == BUS_ID) begin : g_own
      assign gbl_vec_o[b] = irq_w;
    end else begin : g_other
      assign gbl_vec_o[b] = 1'b0;
    end
  end

  assign en_o    = en_w;
  assign stat_o  = stat_w;
  assign irq_o   = irq_w;
  assign rearm_o = rearm_w;

  AST_GBL_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gbl_vec_o)); // R9
  AST_REARM_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_o |=> ((stat_o & ~$past(en_o)) == '0)); // R11
endmodule

// File: tb/bus_irq_unit_bench.sv
module bus_irq_unit_bench;
  localparam int NB  = 16;
  localparam int BID = 3;

  typedef struct {
    logic [14:0] stat;
    logic [14:0] en;
    logic        irq;
    logic        rearm;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 1'b0, ack_wr = 1'b0, raise = 1'b0, pend = 1'b0;
  logic [14:0] en_wd = '0, ack_bits = '0, evt = '0;
  logic [14:0] en_o, stat_o;
  logic irq_o, rearm_o;
  logic [NB-1:0] gbl_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];

  logic [14:0] m_en = '0, m_stat = '0;
  logic m_irq = 1'b0, m_rearm = 1'b0;

  always #2 clk = ~clk;

  bus_irq_unit #(.NUM_BUS(NB), .BUS_ID(BID)) u_bus_irq_unit (
    .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr), .en_wdata_i(en_wd),
    .ack_wr_i(ack_wr), .ack_bits_i(ack_bits), .evt_i(evt), .raise_i(raise),
    .rx_pend_i(pend), .en_o(en_o), .stat_o(stat_o), .irq_o(irq_o),
    .gbl_vec_o(gbl_o), .rearm_o(rearm_o)
  );

  function automatic logic [NB-1:0] gbl_of(logic line);
    logic [NB-1:0] v = '0;
    v[BID] = line;
    return v;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (stat_o !== e.stat || en_o !== e.en || irq_o !== e.irq ||
        rearm_o !== e.rearm || gbl_o !== gbl_of(e.irq)) begin
      errors++;
      $display("FAIL %s: stat=%h en=%h irq=%b rearm=%b gbl=%h expected stat=%h en=%h irq=%b rearm=%b gbl=%h",
               e.tag, stat_o, en_o, irq_o, rearm_o, gbl_o,
               e.stat, e.en, e.irq, e.rearm, gbl_of(e.irq));
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic ew, input logic [14:0] ed, input logic aw,
                      input logic [14:0] ab, input logic [14:0] ev,
                      input logic rs, input logic pd, input string tag);
    exp_t e;
    logic [14:0] ns;
    logic do_raise, ni;
    @(negedge clk);
    en_wr = ew; en_wd = ed; ack_wr = aw; ack_bits = ab;
    evt = ev; raise = rs; pend = pd;
    do_raise = rs || m_rearm;
    for (int k = 0; k < 15; k++) begin
      if (ev[k])              ns[k] = 1'b1;
      else if (aw && ab[k])   ns[k] = 1'b0;
      else                    ns[k] = m_stat[k];
      if (do_raise && !m_en[k]) ns[k] = 1'b0;
    end
    ni = m_irq;
    if (do_raise && ns != 0) ni = 1'b1;
    else if (aw && ns == 0)  ni = 1'b0;
    m_rearm = aw && ab[2] && m_stat[2] && pd;
    m_stat  = ns;
    m_irq   = ni;
    if (ew) m_en = ed;
    e.stat = m_stat; e.en = m_en; e.irq = m_irq; e.rearm = m_rearm; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: pops one expectation per clock, just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (en_o !== '0 || stat_o !== '0 || irq_o !== 1'b0 || gbl_o !== '0 || rearm_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: en=%h stat=%h irq=%b gbl=%h rearm=%b expected all zero",
               en_o, stat_o, irq_o, gbl_o, rearm_o);
    end
    rst_n = 1'b1;

    step(1, 15'h0005, 0, 0, 0, 0, 0, "R2 enable write");
    step(0, 0, 0, 0, 15'h0001, 0, 0, "R3/R12 event without raise");
    step(0, 0, 0, 0, 0, 1, 0, "R6 raise asserts line");
    step(0, 0, 0, 0, 15'h0002, 1, 0, "R6 raise prunes disabled bit");
    step(0, 0, 1, 15'h0001, 0, 0, 0, "R8 clear to zero drops line");
    step(0, 0, 0, 0, 15'h0005, 1, 0, "R6 raise with two bits");
    step(0, 0, 1, 15'h0001, 0, 0, 0, "R8 clear leaving nonzero keeps line");
    step(0, 0, 1, 15'h0004, 15'h0004, 0, 0, "R5 event beats clear");
    step(1, 15'h0001, 0, 0, 0, 0, 0, "R2 enable narrowed");
    step(0, 0, 0, 0, 0, 1, 0, "R7 zero-masked raise keeps line");
    step(0, 0, 1, 15'h0000, 0, 0, 0, "R8 clear write on zero status drops line");
    step(1, 15'h7FFF, 0, 0, 0, 0, 0, "R2 enable all");
    step(0, 0, 0, 0, 15'h6000, 0, 0, "R3 high bits set");
    step(0, 0, 1, 15'h2000, 0, 0, 0, "R4 clear bit 13 only");
    step(0, 0, 1, 15'h4000, 15'h0008, 0, 0, "R4 clear bit 14, set bit 3");
    step(0, 0, 1, 15'h0008, 15'h0004, 1, 0, "R6 rx done raised");
    step(0, 0, 1, 15'h0004, 0, 0, 1, "R10 ack with pending rearms");
    step(0, 0, 0, 0, 15'h0004, 0, 1, "R11 rearm cycle raises");
    step(0, 0, 1, 15'h0004, 0, 0, 0, "R10 no pending no rearm");
    step(0, 0, 1, 15'h0004, 0, 0, 1, "R10 status clear no rearm");
    step(0, 0, 0, 0, 15'h0004, 1, 1, "R6 rx done again");
    step(0, 0, 1, 15'h0010, 0, 0, 1, "R10 other bit ack no rearm");
    step(0, 0, 0, 0, 0, 0, 0, "R9 idle hold");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule